// File: doc/BRIEF.md
# Flash Boot Record Copy Engine

After reset and a start pulse, this engine loads a program image from nonvolatile storage into working memory. It reads the flash one byte at a time through a request/response port. Reading begins at a base offset, so the image can follow a configuration bitstream in the same device. The engine expects a chain of records. Each record opens with an 8-byte header that holds a byte count and a destination address. The payload bytes that follow are packed into 32-bit words with byte-lane strobes and sent to a memory write port.

The chain has no fixed length. It ends at one of two sentinel counts. A count of zero means the address field is where the processor starts, so the engine presents that address and pulses a launch signal. A count with every bit set makes the engine stop in a halted state. This makes a blank, erased device safe, because erased flash reads back as all ones.

Top module: `boot_record_loader`

## Requirements
- R1: After reset, busy_o, jump_o, done_jump_o, halted_o, fl_req_valid_o and mw_valid_o are 0, and byte_cnt_o is 0.
- R2: A run starts when start_i is high in the idle state. The first flash request carries base_off_i. Each later accepted request carries the previous address plus one. A request that is not accepted holds its address.
- R3: Each header is eight flash bytes. The first four form the count and the last four form the address, each assembled least significant byte first.
- R4: For a count other than 0 and other than 0xFFFFFFFF, the next count bytes are written to memory at addresses A, A+1, and so on. Byte A+k goes to byte lane (A+k) mod 4 of the word at address (A+k) with bits [1:0] cleared.
- R5: A word whose bytes run out before lane 3, or whose first byte starts above lane 0, is written with only the strobes of the lanes it carries. Lanes outside the record keep their memory contents.
- R6: A count of 0 sets jump_addr_o to the address field and raises jump_o for exactly one cycle. done_jump_o then rises and stays high, and busy_o falls.
- R7: A count of 0xFFFFFFFF ignores the address field and sets halted_o. No launch pulse, memory write or further flash request follows.
- R8: After a payload, the next header is read from the flash byte that directly follows the payload. Any number of records can be chained.
- R9: While mw_ready_i is low, mw_valid_o stays high with address, data and strobes unchanged. No flash request is made while a write is pending.
- R10: byte_cnt_o counts the payload bytes taken from flash since the start of the run.
- R11: start_i is ignored while a run is in progress and after a run has ended. Only reset leaves the launch or halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a load run (honoured only when idle) |
| base_off_i | input | FA_W | Flash byte offset of the first header |
| fl_req_valid_o | output | 1 | Flash byte read request |
| fl_req_addr_o | output | FA_W | Flash byte address of the request |
| fl_req_ready_i | input | 1 | Flash accepts the request |
| fl_rsp_valid_i | input | 1 | Flash returns the requested byte |
| fl_rsp_data_i | input | 8 | Returned byte |
| mw_valid_o | output | 1 | Memory write request |
| mw_addr_o | output | MA_W | Word-aligned byte address |
| mw_data_o | output | 8*NB | Write data, lane i in bits [8i+7:8i] |
| mw_strb_o | output | NB | Byte-lane write enables |
| mw_ready_i | input | 1 | Memory accepts the write |
| busy_o | output | 1 | Run in progress |
| jump_o | output | 1 | One-cycle launch pulse |
| jump_addr_o | output | MA_W | Processor start address |
| done_jump_o | output | 1 | Run ended with a launch record |
| halted_o | output | 1 | Run ended on the all-ones record |
| byte_cnt_o | output | CNT_W | Payload bytes copied |

## Verification
Timing is counted from the flash response edge, because flash latency and memory stalls are arbitrary. A payload word goes onto the write port the cycle after its last byte's response. The launch pulse comes two cycles after the last header byte: one cycle to decode the header, then the registered pulse. Halt is reached one cycle after decode. The bench does not rely on fixed delays. It polls the terminal flags at falling edges under a bounded wait, then settles three more cycles before it compares memory, address and counter results. Edge monitors record per-cycle behaviour (request order, pulse width, write hold, requests after the end) for checks made after each run.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  localparam int unsigned REC_FIELD_W   = 32;
  localparam int unsigned REC_HDR_BYTES = 8;

  typedef enum logic [3:0] {
    LD_IDLE,
    LD_HREQ,
    LD_HWAIT,
    LD_DECODE,
    LD_PREQ,
    LD_PWAIT,
    LD_WRITE,
    LD_RUN,
    LD_HALT
  } ld_state_e;
endpackage

// File: rtl/bootld_hdr_asm.sv
module bootld_hdr_asm #(
  parameter int unsigned NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  byte_vld_i,
  input  logic [7:0]            byte_i,
  output logic                  last_o,
  output logic [8*NBYTES-1:0]   hdr_o
);
  localparam int unsigned CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [CW-1:0]        cnt_q, cnt_d;
  logic [8*NBYTES-1:0]  sh_q, sh_d;

  // bytes enter at the top and move down, so the first byte ends in bits [7:0]
  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (byte_vld_i) begin
      sh_d  = {byte_i, sh_q[8*NBYTES-1:8]};
      cnt_d = (cnt_q == CW'(NBYTES-1)) ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign last_o = byte_vld_i && (cnt_q == CW'(NBYTES-1));
  assign hdr_o  = sh_q;
endmodule

// File: rtl/bootld_word_pack.sv
module bootld_word_pack #(
  parameter int unsigned NB = 4,
  localparam int unsigned LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  input  logic [LW-1:0]   lane_i,
  output logic [8*NB-1:0] data_o,
  output logic [NB-1:0]   strb_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic       hit;
    logic [7:0] byte_q, byte_d;
    logic       en_q, en_d;

    assign hit = byte_vld_i && (lane_i == LW'(g));

    always_comb begin
      byte_d = byte_q;
      en_d   = en_q;
      if (clr_i) begin
        en_d = 1'b0;
      end else if (hit) begin
        byte_d = byte_i;
        en_d   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        en_q   <= 1'b0;
      end else begin
        byte_q <= byte_d;
        en_q   <= en_d;
      end
    end

    assign data_o[8*g +: 8] = byte_q;
    assign strb_o[g]        = en_q;
  end
endmodule

// File: rtl/boot_record_loader.sv
module boot_record_loader
  import bootld_pkg::*;
#(
  parameter int unsigned FA_W  = 24,
  parameter int unsigned MA_W  = 32,
  parameter int unsigned NB    = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [FA_W-1:0]  base_off_i,
  output logic             fl_req_valid_o,
  output logic [FA_W-1:0]  fl_req_addr_o,
  input  logic             fl_req_ready_i,
  input  logic             fl_rsp_valid_i,
  input  logic [7:0]       fl_rsp_data_i,
  output logic             mw_valid_o,
  output logic [MA_W-1:0]  mw_addr_o,
  output logic [8*NB-1:0]  mw_data_o,
  output logic [NB-1:0]    mw_strb_o,
  input  logic             mw_ready_i,
  output logic             busy_o,
  output logic             jump_o,
  output logic [MA_W-1:0]  jump_addr_o,
  output logic             done_jump_o,
  output logic             halted_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  localparam int unsigned LW = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned FW = REC_FIELD_W;
  localparam int unsigned HB = REC_HDR_BYTES;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  ld_state_e        st_q, st_d;
  logic [FA_W-1:0]  fptr_q, fptr_d;
  logic [FW-1:0]    remain_q, remain_d;
  logic [MA_W-1:0]  waddr_q, waddr_d;
  logic [MA_W-1:0]  wline_q, wline_d;
  logic [MA_W-1:0]  jaddr_q, jaddr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             jump_q, jump_d;

  logic             req_acc, hdr_vld, pay_vld, wr_acc, hdr_last, hdr_clr;
  logic [8*HB-1:0]  hdr;
  logic [FW-1:0]    rec_len, rec_addr;
  logic [LW-1:0]    lane;

  assign fl_req_valid_o = (st_q == LD_HREQ) || (st_q == LD_PREQ);
  assign fl_req_addr_o  = fptr_q;
  assign req_acc        = fl_req_valid_o && fl_req_ready_i;
  assign hdr_vld        = (st_q == LD_HWAIT) && fl_rsp_valid_i;
  assign pay_vld        = (st_q == LD_PWAIT) && fl_rsp_valid_i;
  assign wr_acc         = (st_q == LD_WRITE) && mw_ready_i;
  assign hdr_clr        = (st_q == LD_IDLE) && start_i;
  assign rec_len        = hdr[FW-1:0];
  assign rec_addr       = hdr[2*FW-1:FW];
  assign lane           = waddr_q[LW-1:0];

  bootld_hdr_asm #(.NBYTES(HB)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (hdr_clr),
    .byte_vld_i (hdr_vld),
    .byte_i     (fl_rsp_data_i),
    .last_o     (hdr_last),
    .hdr_o      (hdr)
  );

  bootld_word_pack #(.NB(NB)) u_pack (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (wr_acc),
    .byte_vld_i (pay_vld),
    .byte_i     (fl_rsp_data_i),
    .lane_i     (lane),
    .data_o     (mw_data_o),
    .strb_o     (mw_strb_o)
  );

  always_comb begin
    st_d     = st_q;
    fptr_d   = fptr_q;
    remain_d = remain_q;
    waddr_d  = waddr_q;
    wline_d  = wline_q;
    jaddr_d  = jaddr_q;
    cnt_d    = cnt_q;
    jump_d   = 1'b0;
    unique case (st_q)
      LD_IDLE: begin
        if (start_i) begin
          st_d   = LD_HREQ;
          fptr_d = base_off_i;
          cnt_d  = '0;
        end
      end
      LD_HREQ: begin
        if (req_acc) begin
          fptr_d = fptr_q + FA_W'(1);
          st_d   = LD_HWAIT;
        end
      end
      LD_HWAIT: begin
        if (fl_rsp_valid_i) st_d = hdr_last ? LD_DECODE : LD_HREQ;
      end
      LD_DECODE: begin
        if (rec_len == '0) begin
          st_d    = LD_RUN;
          jaddr_d = MA_W'(rec_addr);
          jump_d  = 1'b1;
        end else if (&rec_len) begin
          st_d = LD_HALT;
        end else begin
          remain_d = rec_len;
          waddr_d  = MA_W'(rec_addr);
          st_d     = LD_PREQ;
        end
      end
      LD_PREQ: begin
        if (req_acc) begin
          fptr_d = fptr_q + FA_W'(1);
          st_d   = LD_PWAIT;
        end
      end
      LD_PWAIT: begin
        if (fl_rsp_valid_i) begin
          waddr_d  = waddr_q + MA_W'(1);
          remain_d = remain_q - FW'(1);
          cnt_d    = cnt_q + CNT_W'(1);
          wline_d  = {waddr_q[MA_W-1:LW], LW'(0)};
          st_d     = ((lane == LW'(NB-1)) || (remain_q == FW'(1))) ? LD_WRITE : LD_PREQ;
        end
      end
      LD_WRITE: begin
        if (mw_ready_i) st_d = (remain_q == '0) ? LD_HREQ : LD_PREQ;
      end
      LD_RUN, LD_HALT: ;
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= LD_IDLE;
      fptr_q   <= '0;
      remain_q <= '0;
      waddr_q  <= '0;
      wline_q  <= '0;
      jaddr_q  <= '0;
      cnt_q    <= '0;
      jump_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      fptr_q   <= fptr_d;
      remain_q <= remain_d;
      waddr_q  <= waddr_d;
      wline_q  <= wline_d;
      jaddr_q  <= jaddr_d;
      cnt_q    <= cnt_d;
      jump_q   <= jump_d;
    end
  end

  assign mw_valid_o  = (st_q == LD_WRITE);
  assign mw_addr_o   = wline_q;
  assign busy_o      = (st_q != LD_IDLE) && (st_q != LD_RUN) && (st_q != LD_HALT);
  assign jump_o      = jump_q;
  assign jump_addr_o = jaddr_q;
  assign done_jump_o = (st_q == LD_RUN);
  assign halted_o    = (st_q == LD_HALT);
  assign byte_cnt_o  = cnt_q;
endmodule

// File: rtl/boot_record_loader_chk.sv
module boot_record_loader_chk #(
  parameter int unsigned FA_W  = 24,
  parameter int unsigned MA_W  = 32,
  parameter int unsigned NB    = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fl_req_valid_o,
  input logic [FA_W-1:0]  fl_req_addr_o,
  input logic             fl_req_ready_i,
  input logic             mw_valid_o,
  input logic [MA_W-1:0]  mw_addr_o,
  input logic [8*NB-1:0]  mw_data_o,
  input logic [NB-1:0]    mw_strb_o,
  input logic             mw_ready_i,
  input logic             busy_o,
  input logic             jump_o,
  input logic             done_jump_o,
  input logic             halted_o
);
  localparam int unsigned LW = (NB > 1) ? $clog2(NB) : 1;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid_o && !fl_req_ready_i |=> fl_req_valid_o && $stable(fl_req_addr_o));

  assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid_o |-> (mw_addr_o[LW-1:0] == '0));

  assert_strb_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid_o |-> (mw_strb_o != '0));

  assert_jump_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |=> !jump_o);

  assert_jump_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> done_jump_o && !busy_o);

  assert_end_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o || done_jump_o) |-> !fl_req_valid_o && !mw_valid_o && !busy_o);

  assert_end_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted_o && done_jump_o));

  assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid_o && !mw_ready_i |=> mw_valid_o && $stable(mw_addr_o)
                                  && $stable(mw_data_o) && $stable(mw_strb_o));

  assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mw_valid_o && fl_req_valid_o));

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);

  assert_jump_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_jump_o |=> done_jump_o);
endmodule

bind boot_record_loader boot_record_loader_chk #(
  .FA_W(FA_W), .MA_W(MA_W), .NB(NB), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_boot_record_loader.sv
`timescale 1ns/1ps
module tb_boot_record_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] base_off = '0;
  logic        fl_req_valid, fl_req_ready, fl_rsp_valid;
  logic [23:0] fl_req_addr;
  logic [7:0]  fl_rsp_data;
  logic        mw_valid, mw_ready;
  logic [31:0] mw_addr, mw_data;
  logic [3:0]  mw_strb;
  logic        busy, jump, done_jump, halted;
  logic [31:0] jump_addr, byte_cnt;

  always #2.5 clk = ~clk;

  boot_record_loader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_off_i(base_off),
    .fl_req_valid_o(fl_req_valid), .fl_req_addr_o(fl_req_addr), .fl_req_ready_i(fl_req_ready),
    .fl_rsp_valid_i(fl_rsp_valid), .fl_rsp_data_i(fl_rsp_data),
    .mw_valid_o(mw_valid), .mw_addr_o(mw_addr), .mw_data_o(mw_data), .mw_strb_o(mw_strb),
    .mw_ready_i(mw_ready), .busy_o(busy), .jump_o(jump), .jump_addr_o(jump_addr),
    .done_jump_o(done_jump), .halted_o(halted), .byte_cnt_o(byte_cnt)
  );

  // ---------------- flash and memory models ----------------
  logic [7:0] fl_mem [0:511];
  logic [7:0] mb     [0:255];
  logic [7:0] exp_mb [0:255];
  bit         fl_stall = 0, mw_stall = 0;
  int         fl_lat = 0;
  int         cyc = 0;
  logic       fl_pend;
  int         fl_cnt;
  logic [8:0] fl_a;
  int         n_req, seq_err, n_wr, n_jump, late_req, hold_err;
  logic [23:0] first_addr, last_addr;
  logic       pstall;
  logic [31:0] p_addr, p_data;
  logic [3:0] p_strb;

  assign fl_req_ready = !fl_stall || cyc[0];
  assign fl_rsp_valid = fl_pend && (fl_cnt == 0);
  assign fl_rsp_data  = fl_mem[fl_a];
  assign mw_ready     = !mw_stall || (cyc[1] && cyc[0]);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      fl_pend <= 1'b0; fl_cnt <= 0; fl_a <= '0;
      n_req <= 0; seq_err <= 0; n_wr <= 0; n_jump <= 0; late_req <= 0; hold_err <= 0;
      first_addr <= '0; last_addr <= '0; pstall <= 1'b0;
      for (int i = 0; i < 256; i++) mb[i] <= 8'h00;
    end else begin
      if (fl_rsp_valid) fl_pend <= 1'b0;
      else if (fl_pend) fl_cnt <= fl_cnt - 1;
      if (fl_req_valid && fl_req_ready) begin
        fl_pend <= 1'b1; fl_cnt <= fl_lat; fl_a <= fl_req_addr[8:0];
        n_req <= n_req + 1;
        if (n_req == 0) first_addr <= fl_req_addr;
        else if (fl_req_addr != last_addr + 24'd1) seq_err <= seq_err + 1;
        last_addr <= fl_req_addr;
      end
      if ((halted || done_jump) && fl_req_valid) late_req <= late_req + 1;
      if (jump) n_jump <= n_jump + 1;
      if (pstall && (!mw_valid || mw_addr != p_addr || mw_data != p_data || mw_strb != p_strb))
        hold_err <= hold_err + 1;
      pstall <= mw_valid && !mw_ready;
      p_addr <= mw_addr; p_data <= mw_data; p_strb <= mw_strb;
      if (mw_valid && mw_ready) begin
        n_wr <= n_wr + 1;
        for (int l = 0; l < 4; l++)
          if (mw_strb[l]) mb[8'(mw_addr[7:0] + 8'(l))] <= mw_data[8*l +: 8];
      end
    end
  end

  // ---------------- bench helpers ----------------
  int ntot = 0, nbad = 0;
  bit fin = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int s, int i);
    return 8'(s * 37 + i * 11 + 5);
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) fl_mem[a + k] = v[8*k +: 8];
  endtask

  task automatic blank();
    for (int i = 0; i < 512; i++) fl_mem[i] = 8'hFF;
    for (int i = 0; i < 256; i++) exp_mb[i] = 8'h00;
  endtask

  // a record with payload; returns next flash offset
  task automatic add_rec(inout int off, input int len, input int addr, input int seed);
    put32(off, 32'(len)); put32(off + 4, 32'(addr));
    for (int i = 0; i < len; i++) begin
      fl_mem[off + 8 + i] = pat(seed, i);
      exp_mb[8'(addr + i)] = pat(seed, i);
    end
    off = off + 8 + len;
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < 256; i++) if (mb[i] !== exp_mb[i]) m++;
    return m;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input bit restart_mid);
    int t = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (restart_mid) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!(done_jump || halted) && t < 4000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
  endtask

  // base, len, addr
  localparam logic [23:0] VEC [6] = '{
    {8'd0,  8'd8,  8'h10},
    {8'd4,  8'd5,  8'h20},
    {8'd16, 8'd6,  8'h31},
    {8'd3,  8'd1,  8'h43},
    {8'd32, 8'd11, 8'h52},
    {8'd7,  8'd4,  8'h66}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      nbad++;
      $display("FAIL watchdog R1: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", ntot + 1, nbad);
      $finish;
    end
  end

  initial begin
    int off;
    logic [31:0] ja;
    // ---- R1 reset state
    blank();
    do_reset();
    check(!busy && !jump && !done_jump && !halted, "R1 status idle", {busy, jump, done_jump, halted}, 0);
    check(!fl_req_valid && !mw_valid, "R1 ports idle", {fl_req_valid, mw_valid}, 0);
    check(byte_cnt == 0, "R1 byte_cnt", byte_cnt, 0);

    // ---- table walk: one payload record then a launch record
    for (int v = 0; v < 6; v++) begin
      int b, ln, ad;
      b = int'(VEC[v][23:16]); ln = int'(VEC[v][15:8]); ad = int'(VEC[v][7:0]);
      blank();
      off = b;
      add_rec(off, ln, ad, v);
      ja = 32'h1234_5600 | 32'(v);
      put32(off, 32'h0); put32(off + 4, ja);
      base_off = 24'(b);
      fl_lat = v % 3; fl_stall = v[0]; mw_stall = v[0];
      do_reset();
      run(1'b0);
      check(done_jump && !halted, "R6 launch reached", {done_jump, halted}, 2);
      check(jump_addr == ja, "R3 R6 start address", jump_addr, ja);
      check(n_jump == 1, "R6 pulse width", n_jump, 1);
      check(mism() == 0, "R4 R5 memory image", mism(), 0);
      check(byte_cnt == 32'(ln), "R10 byte count", byte_cnt, ln);
      check(first_addr == 24'(b) && seq_err == 0, "R2 request order", first_addr, b);
      check(hold_err == 0, "R9 write hold", hold_err, 0);
      check(!busy, "R6 busy low", busy, 0);
    end

    // ---- R7 erased flash
    blank();
    base_off = 24'd40; fl_lat = 1; fl_stall = 0; mw_stall = 0;
    do_reset();
    run(1'b0);
    repeat (30) @(negedge clk);
    check(halted && !done_jump, "R7 erased halts", {halted, done_jump}, 2);
    check(n_jump == 0 && n_wr == 0, "R7 no launch no write", {n_jump, n_wr}, 0);
    check(late_req == 0 && n_req == 8, "R7 reading stops", n_req, 8);

    // ---- R7 halt record after a real record, address field nonzero
    blank();
    off = 0;
    add_rec(off, 3, 8'h81, 9);
    put32(off, 32'hFFFF_FFFF); put32(off + 4, 32'h0000_0000);
    base_off = 24'd0;
    do_reset();
    run(1'b0);
    check(halted && n_jump == 0, "R7 halt after copy", {halted, n_jump}, 2);
    check(mism() == 0 && byte_cnt == 3, "R5 R7 partial copy kept", mism(), 0);

    // ---- R8 chain with stalls, R11 mid-run start ignored
    blank();
    off = 2;
    add_rec(off, 5, 8'h90, 11);
    add_rec(off, 7, 8'hA3, 12);
    ja = 32'hCAFE_F00D;
    put32(off, 32'h0); put32(off + 4, ja);
    base_off = 24'd2; fl_lat = 2; fl_stall = 1; mw_stall = 1;
    do_reset();
    run(1'b1);
    check(mism() == 0, "R8 chained records", mism(), 0);
    check(byte_cnt == 12, "R10 chained count", byte_cnt, 12);
    check(jump_addr == ja && done_jump, "R3 R8 start address", jump_addr, ja);
    check(first_addr == 24'd2 && seq_err == 0, "R11 R2 no restart", seq_err, 0);
    check(hold_err == 0, "R9 hold under stall", hold_err, 0);

    // ---- R11 start after the end has no effect
    begin
      int nr;
      nr = n_req;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (30) @(negedge clk);
      check(n_req == nr && done_jump && !busy, "R11 start after end", n_req, nr);
      check(n_jump == 1, "R11 no second pulse", n_jump, 1);
    end

    fin = 1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule